// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into start/stop asynchronous characters on a single serial line. A host hands over one byte at a time, together with a per-character marker bit, on a valid/ready input. The byte lands in a one-entry data register. The data register feeds a shift register, so the next character can wait while the current one is on the line. The following frame then starts on the tick right after the last stop bit, with no idle bit in between.

Plain control pins set the character format. They select the data length (seven or eight bits), the stop length (one or two bits) and the parity (none, even or odd). They can also enable a marker bit that tags each character as an address or as data, and, for 8-bit characters, whether the most significant bit goes first. Bit timing comes from an external single-cycle baud tick: every bit on the line lasts from one tick to the next. Two status outputs, usable directly as interrupt requests, report that the data register is empty and that transmission has fully ended.

Back-pressure rule: `in_ready` is high exactly when the data register is empty. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The host must hold the byte, the marker bit and `in_valid` steady until that edge. The format pins are sampled when a character moves from the data register into the shift register. The host changes them only while `end_flag` is high.

Top module: `sertx_top`

## Requirements
- R1: With `fmt_len7`=1 only bits 6..0 of the byte are sent, as seven data bits. With `fmt_len7`=0 all eight bits are sent.
- R2: Every frame starts with one low start bit and ends with one high stop bit (`fmt_stop2`=0) or two high stop bits (`fmt_stop2`=1).
- R3: `fmt_par` 2'b01 appends an even-parity bit and 2'b10 appends an odd-parity bit after the data bits. The codes 2'b00 and 2'b11 append none. Even parity makes the data bits plus the parity bit hold an even count of ones; odd parity makes that count odd.
- R4: With `fmt_mp`=1 the `in_mpb` value of the character is sent as one bit right after the data bits, and `fmt_par` is ignored.
- R5: With `fmt_msb`=1 and 8-bit data, bit 7 is sent first. In every other case bit 0 is sent first, which includes 7-bit data with `fmt_msb`=1.
- R6: `in_ready` is high exactly when the data register is empty. While a frame shifts, one more byte can be accepted, and its start bit follows the previous frame's last stop bit with no gap.
- R7: `empty_flag` is high when the data register is empty. It goes low in the cycle after a byte is accepted.
- R8: `end_flag` is high only when no frame is shifting and the data register is empty. Accepting a byte clears it in the next cycle, and it rises again on the tick that ends the last stop bit.
- R9: While no frame is shifting, or while `enable` is low, `txd` is high. Taking `enable` low stops the shifter, and no frame is loaded until `enable` returns high.
- R10: After reset `txd`, `empty_flag`, `end_flag` and `in_ready` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| fmt_len7 | input | 1 | 1 = seven data bits, 0 = eight |
| fmt_stop2 | input | 1 | 1 = two stop bits |
| fmt_par | input | 2 | Parity select: 01 even, 10 odd, 00/11 none |
| fmt_mp | input | 1 | Append the marker bit instead of parity |
| fmt_msb | input | 1 | Most significant bit first (8-bit only) |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Data register can take a byte |
| in_data | input | 8 | Byte to send |
| in_mpb | input | 1 | Marker bit value for this character |
| txd | output | 1 | Serial output, high when idle |
| empty_flag | output | 1 | Data register empty event |
| end_flag | output | 1 | Transmission-end event |

## Verification
The assertions assume that `in_valid`, `in_data` and `in_mpb` stay steady until they are accepted. They also assume that `baud_tick` pulses for a single cycle. The bench generates the tick on a fixed divider, so that assumption always holds. Its driver raises `in_valid` away from the clock edge and drops it only after the accepting edge. It changes the format pins only while `end_flag` is high, so every character is framed with the format that the expected-value function used for it.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef struct packed {
    logic       len7;
    logic       stop2;
    logic [1:0] par;
    logic       mp;
    logic       msb;
  } fmt_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_mpb,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data_q,
  output logic          mpb_q
);
  logic accept;

  assign in_ready = !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
      mpb_q  <= 1'b0;
    end else if (accept) begin
      full   <= 1'b1;
      data_q <= in_data;
      mpb_q  <= in_mpb;
    end else if (take) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = DW + 4,
  parameter int CW = $clog2(FW + 1)
) (
  input  fmt_t          fmt,
  input  logic [DW-1:0] data,
  input  logic          mpb,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] nbits
);
  localparam int SHORT_W = DW - 1;

  logic [DW-1:0] masked;
  logic [DW-1:0] ordered;
  logic [DW-1:0] reversed;
  logic          use_par;
  logic          extra_on;
  logic          extra_bit;
  int unsigned   dlen;

  assign masked = fmt.len7 ? {1'b0, data[SHORT_W-1:0]} : data;

  for (genvar g = 0; g < DW; g++) begin : g_rev
    assign reversed[g] = masked[DW-1-g];
  end

  assign ordered  = (fmt.msb && !fmt.len7) ? reversed : masked;
  assign use_par  = !fmt.mp && (fmt.par == PAR_EVEN || fmt.par == PAR_ODD);
  assign extra_on = fmt.mp || use_par;
  assign dlen     = fmt.len7 ? SHORT_W : DW;

  always_comb begin
    if (fmt.mp) extra_bit = mpb;
    else        extra_bit = (^masked) ^ (fmt.par == PAR_ODD);
  end

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(dlen)) frame[1+i] = ordered[i];
    end
    if (extra_on) frame[1+dlen] = extra_bit;
    nbits = CW'(2 + dlen + (extra_on ? 1 : 0) + (fmt.stop2 ? 1 : 0));
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int FW = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          baud_tick,
  input  logic          hold_full,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] nbits,
  output logic          take,
  output logic          busy,
  output logic          txd
);
  logic [FW-1:0] shreg;
  logic [CW-1:0] left;
  logic          last_tick;

  assign last_tick = busy && baud_tick && (left == CW'(1));
  assign take      = enable && hold_full && (!busy || last_tick);
  assign txd       = !busy || shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (!enable) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      shreg <= frame;
      left  <= nbits;
    end else if (busy && baud_tick) begin
      if (left == CW'(1)) busy <= 1'b0;
      shreg <= {1'b1, shreg[FW-1:1]};
      left  <= left - CW'(1);
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       baud_tick,
  input  logic       fmt_len7,
  input  logic       fmt_stop2,
  input  logic [1:0] fmt_par,
  input  logic       fmt_mp,
  input  logic       fmt_msb,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_mpb,
  output logic       txd,
  output logic       empty_flag,
  output logic       end_flag
);
  fmt_t               fmt;
  logic               take;
  logic               full;
  logic               busy;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_mpb;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign fmt = '{len7: fmt_len7, stop2: fmt_stop2, par: fmt_par,
                 mp: fmt_mp, msb: fmt_msb};

  sertx_hold #(.DW(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mpb(in_mpb), .take(take), .full(full),
    .data_q(hold_data), .mpb_q(hold_mpb)
  );

  sertx_framer #(.DW(DATA_W), .FW(FRAME_W), .CW(CNT_W)) framer_i (
    .fmt(fmt), .data(hold_data), .mpb(hold_mpb), .frame(frame), .nbits(nbits)
  );

  sertx_shift #(.FW(FRAME_W), .CW(CNT_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .baud_tick(baud_tick),
    .hold_full(full), .frame(frame), .nbits(nbits), .take(take),
    .busy(busy), .txd(txd)
  );

  assign empty_flag = !full;
  assign end_flag   = !busy && !full;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic empty_flag,
  input logic end_flag
);
  AST_DISABLED_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> txd) else $error("disabled line not at mark"); // R9

  AST_END_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> txd) else $error("idle line not at mark"); // R9

  AST_END_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> empty_flag) else $error("end with full register"); // R8

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !empty_flag && !end_flag) else $error("write did not clear flags"); // R7

  AST_END_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) && $past(enable) |-> $past(txd)) else $error("end not after stop bit"); // R2
endmodule

bind sertx_top sertx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb_top;
  localparam int DIV = 4;

  typedef struct {
    logic [11:0] bits;
    int          n;
    bit          follow;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       baud_tick;
  logic       fmt_len7 = 1'b0, fmt_stop2 = 1'b0, fmt_mp = 1'b0, fmt_msb = 1'b0;
  logic [1:0] fmt_par = 2'b00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_mpb = 1'b0;
  logic       txd, empty_flag, end_flag;

  int tests = 0;
  int fails = 0;
  int tick_cnt = 0;
  exp_t exp_q[$];
  bit   follow_next = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) tick_cnt <= (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
  assign baud_tick = (tick_cnt == DIV - 1);

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .baud_tick(baud_tick),
    .fmt_len7(fmt_len7), .fmt_stop2(fmt_stop2), .fmt_par(fmt_par),
    .fmt_mp(fmt_mp), .fmt_msb(fmt_msb), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_mpb(in_mpb), .txd(txd),
    .empty_flag(empty_flag), .end_flag(end_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected line bits in time order, built from R1..R5.
  function automatic exp_t build(input logic [7:0] d, input logic mpb);
    exp_t e;
    int   len;
    int   ones;
    bit   q[$];
    len = fmt_len7 ? 7 : 8;
    q.push_back(1'b0);
    ones = 0;
    for (int i = 0; i < len; i++) begin
      int k;
      k = (fmt_msb && !fmt_len7) ? 7 - i : i;
      q.push_back(d[k]);
      ones += d[k];
    end
    if (fmt_mp) q.push_back(mpb);
    else if (fmt_par == 2'b01) q.push_back(ones % 2);
    else if (fmt_par == 2'b10) q.push_back(1 - (ones % 2));
    q.push_back(1'b1);
    if (fmt_stop2) q.push_back(1'b1);
    e.bits = '1;
    foreach (q[i]) e.bits[i] = q[i];
    e.n = q.size();
    e.follow = 0;
    return e;
  endfunction

  // Line monitor: one sample per bit interval, taken just before the tick edge.
  bit          mon_busy = 0;
  exp_t        cur;
  logic [11:0] got;
  int          idx = 0;
  int          gap = 0;
  always @(negedge clk) begin
    if (rst_n && baud_tick) begin
      if (!mon_busy) begin
        if (txd === 1'b0) begin
          if (exp_q.size() == 0) check("R9 unexpected start", 32'(txd), 32'd1);
          else begin
            cur = exp_q.pop_front();
            if (cur.follow) check("R6 gap between frames", 32'(gap), 32'd0);
            got = '1; got[0] = 1'b0; idx = 1; mon_busy = 1;
          end
          gap = 0;
        end else gap++;
      end else begin
        got[idx] = txd;
        idx++;
        if (idx == cur.n) begin
          check("R1-frame R2 R3 R4 R5 bits", 32'(got), 32'(cur.bits));
          mon_busy = 0;
        end
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic mpb);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mpb = mpb;
    while (!in_ready) @(negedge clk);
    begin
      exp_t e;
      e = build(d, mpb);
      e.follow = follow_next;
      exp_q.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 empty low after write", 32'(empty_flag), 32'd0);
    check("R8 end cleared by write", 32'(end_flag), 32'd0);
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!end_flag) @(negedge clk);
    repeat (DIV + 1) @(negedge clk);
    check("R8 end high when done", 32'(end_flag), 32'd1);
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);
    check("R9 idle mark", 32'(txd), 32'd1);
  endtask

  task automatic set_fmt(input logic l7, input logic s2, input logic [1:0] p,
                         input logic mp, input logic msb);
    fmt_len7 = l7; fmt_stop2 = s2; fmt_par = p; fmt_mp = mp; fmt_msb = msb;
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      follow_next = (i != 0);
      send(8'($urandom), 1'($urandom));
    end
    follow_next = 0;
    wait_end();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R10 txd reset", 32'(txd), 32'd1);
    check("R10 empty reset", 32'(empty_flag), 32'd1);
    check("R10 end reset", 32'(end_flag), 32'd1);
    check("R10 ready reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    enable = 1'b1;

    // Directed corners
    set_fmt(0, 0, 2'b00, 0, 0); send(8'hA5, 0); wait_end();          // R1 8N1
    set_fmt(1, 0, 2'b00, 0, 0); send(8'hFF, 0); wait_end();          // R1 bit 7 dropped
    set_fmt(0, 1, 2'b01, 0, 0); send(8'h07, 0); wait_end();          // R2 R3 even
    set_fmt(0, 0, 2'b10, 0, 0); send(8'h03, 0); wait_end();          // R3 odd
    set_fmt(0, 0, 2'b11, 0, 0); send(8'h81, 0); wait_end();          // R3 code 11 none
    set_fmt(0, 0, 2'b01, 1, 0); send(8'h01, 1); wait_end();          // R4 mp overrides parity
    set_fmt(0, 0, 2'b00, 0, 1); send(8'h80, 0); wait_end();          // R5 msb first
    set_fmt(1, 0, 2'b00, 0, 1); send(8'h41, 0); wait_end();          // R5 ignored for 7-bit
    set_fmt(0, 1, 2'b10, 0, 1); burst(4);                            // R6 back-to-back

    // R9: disabled transmitter holds the line and loads nothing
    enable = 1'b0;
    set_fmt(0, 0, 2'b00, 0, 0);
    send(8'h00, 0);
    for (int i = 0; i < 8 * DIV; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) check("R9 disabled mark", 32'(txd), 32'd1);
    end
    check("R9 disabled mark", 32'(txd), 32'd1);
    check("R9 no load while disabled", 32'(empty_flag), 32'd0);
    enable = 1'b1;
    wait_end();

    // Random formats and bursts
    for (int b = 0; b < 30; b++) begin
      set_fmt(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      burst(1 + ($urandom % 4));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule